// File: doc/BRIEF.md
# Load-Locked Reservation Monitor

This block tracks one atomic-access reservation for each of several execution contexts. It is the piece that lets load-locked / store-conditional pairs work. A locked load records the physical address of the issuing context and arms that context's reservation. A later store-conditional from the same context succeeds only while that reservation is armed and still covers the same address granule. Every store that actually reaches memory disarms each reservation whose granule it hits, in every context.

The block sits next to the memory request path and sees one request per cycle. Each request carries a context number, a physical address, and three qualifiers: locked, store and uncached. One cycle later it answers with three things. The first is whether the store may be written to memory. The second is the reservation value a cacheable store-conditional observed. The third is a warning pulse. The warning fires each time a context's run of consecutive store-conditional failures reaches another multiple of a programmable period, which flags a likely livelock.

Top module: `resv_monitor`

## Requirements
- R1: A request with valid=1, locked=1 and store=0 stores the full address in the issuing context's reservation and arms it, replacing any earlier reservation of that context. A plain load (valid=1, locked=0, store=0) changes no reservation.
- R2: Two addresses fall in the same granule when they are equal after their low GRAN_BITS bits are ignored. With the default of 4, a granule is 16 bytes.
- R3: For a cacheable store-conditional (store=1, locked=1, uncached=0), sc_result in the following cycle equals the issuing context's armed bit as it was before the request. sc_result holds that value until the next cacheable store-conditional.
- R4: A cacheable store-conditional is permitted only when its context is armed and the request's granule matches the reserved granule. Otherwise store_ok is 0 in the following cycle and the issuing context is disarmed.
- R5: A plain store (store=1, locked=0) always gives store_ok=1 in the following cycle.
- R6: Every permitted store (plain store, successful store-conditional, or uncached store-conditional) disarms each context whose reserved granule matches the store's granule. Contexts holding other granules keep their reservations.
- R7: Each context counts its consecutive failed store-conditionals. warn_pulse is 1 for exactly the cycle after each failure that brings the count to a multiple of WARN_PERIOD.
- R8: A successful store-conditional restarts the issuing context's failure count from zero.
- R9: An uncached store-conditional skips the reservation check. It gives store_ok=1, leaves sc_result unchanged, restarts the context's failure count, and still disarms matching reservations under R6.
- R10: After reset, every reservation is disarmed, every failure count is zero, and store_ok, sc_result and warn_pulse are 0.
- R11: A cycle with no request, or with a load request, gives store_ok=0 in the following cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | A request is presented this cycle |
| req_ctx | input | CTX_W | Issuing context number |
| req_addr | input | ADDR_W | Physical address of the access |
| req_locked | input | 1 | Locked load or store-conditional |
| req_store | input | 1 | Access is a store |
| req_uncached | input | 1 | Access bypasses the reservation check |
| store_ok | output | 1 | The previous cycle's store may be written |
| sc_result | output | 1 | Reservation seen by the last cacheable store-conditional |
| warn_pulse | output | 1 | A failure run just reached a multiple of WARN_PERIOD |

## Verification
The assertions assume that req_ctx always names an existing context when a request is valid, and that the request qualifiers stay low while reset is held. Under that assumption, indexing the reservation bits by the previous cycle's context is always in range. The assertions also assume that at most one request arrives per clock, which the port list enforces. The stimulus drives inputs on the falling edge and returns req_valid to 0 after each request. It uses only context numbers 0 to 3 with the default of four contexts, and holds every qualifier at zero through reset.

// File: rtl/resv_pkg.sv
package resv_pkg;

  typedef enum logic [2:0] {
    OP_IDLE,
    OP_LOAD,
    OP_LL,
    OP_STORE,
    OP_SC,
    OP_SC_UNC
  } op_e;

  // Reduce the request qualifiers to a single operation code.
  function automatic op_e classify(input logic v, input logic lk,
                                   input logic st, input logic un);
    if (!v) return OP_IDLE;
    if (!st) return lk ? OP_LL : OP_LOAD;
    if (!lk) return OP_STORE;
    return un ? OP_SC_UNC : OP_SC;
  endfunction

  // Two addresses share a granule when only bits below gb differ.
  function automatic logic same_granule(input logic [63:0] a,
                                        input logic [63:0] b,
                                        input int unsigned gb);
    return ((a ^ b) >> gb) == 64'd0;
  endfunction

  // Failure phase advances modulo the warning period.
  function automatic int unsigned phase_step(input int unsigned ph,
                                             input int unsigned period);
    return (ph + 1 >= period) ? 0 : ph + 1;
  endfunction

endpackage

// File: rtl/resv_slot.sv
module resv_slot
  import resv_pkg::*;
#(
  parameter int ADDR_W      = 32,
  parameter int GRAN_BITS   = 4,
  parameter int WARN_PERIOD = 100000,
  localparam int PH_W       = $clog2(WARN_PERIOD + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sel,
  input  op_e               op,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic              perform,
  output logic              flag_q,
  output logic [ADDR_W-1:0] addr_q,
  output logic              sc_pass,
  output logic              sc_fail,
  output logic              warn_hit
);

  logic [PH_W-1:0] phase_q;
  logic            gran_hit;
  logic            own_sc;

  assign gran_hit = same_granule(64'(addr_q), 64'(req_addr), GRAN_BITS);
  assign own_sc   = sel && (op == OP_SC);
  assign sc_pass  = own_sc && flag_q && gran_hit;
  assign sc_fail  = own_sc && !(flag_q && gran_hit);
  assign warn_hit = sc_fail && (phase_q == PH_W'(WARN_PERIOD - 1));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      flag_q  <= 1'b0;
      addr_q  <= '0;
      phase_q <= '0;
    end else begin
      if (sel && op == OP_LL) begin
        addr_q <= req_addr;
        flag_q <= 1'b1;
      end else if (sc_fail) begin
        flag_q <= 1'b0;
      end else if (perform && gran_hit) begin
        flag_q <= 1'b0;
      end

      if (sc_fail)
        phase_q <= PH_W'(phase_step(32'(phase_q), WARN_PERIOD));
      else if (sc_pass || (sel && op == OP_SC_UNC))
        phase_q <= '0;
    end
  end

endmodule

// File: rtl/resv_resp.sv
module resv_resp
  import resv_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  op_e  op,
  input  logic own_flag,
  input  logic perform,
  input  logic warn_any,
  output logic store_ok,
  output logic sc_result,
  output logic warn_pulse
);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      store_ok   <= 1'b0;
      sc_result  <= 1'b0;
      warn_pulse <= 1'b0;
    end else begin
      store_ok   <= perform;
      warn_pulse <= warn_any;
      if (op == OP_SC) sc_result <= own_flag;
    end
  end

endmodule

// File: rtl/resv_monitor.sv
module resv_monitor
  import resv_pkg::*;
#(
  parameter int NUM_CTX     = 4,
  parameter int ADDR_W      = 32,
  parameter int GRAN_BITS   = 4,
  parameter int WARN_PERIOD = 100000,
  localparam int CTX_W      = (NUM_CTX > 1) ? $clog2(NUM_CTX) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic [CTX_W-1:0]  req_ctx,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic              req_locked,
  input  logic              req_store,
  input  logic              req_uncached,
  output logic              store_ok,
  output logic              sc_result,
  output logic              warn_pulse
);

  op_e                op;
  logic [NUM_CTX-1:0] lock_flags;
  logic [NUM_CTX-1:0] pass_vec;
  logic [NUM_CTX-1:0] fail_vec;
  logic [NUM_CTX-1:0] warn_vec;
  logic [ADDR_W-1:0]  lock_addrs [NUM_CTX];

  // Named internal events, also observed by the checker.
  logic sc_pass_any;
  logic sc_fail_any;
  logic perform;
  logic own_flag;

  assign op          = classify(req_valid, req_locked, req_store, req_uncached);
  assign sc_pass_any = |pass_vec;
  assign sc_fail_any = |fail_vec;
  assign perform     = (op == OP_STORE) || (op == OP_SC_UNC) || sc_pass_any;
  assign own_flag    = (int'(req_ctx) < NUM_CTX) ? lock_flags[req_ctx] : 1'b0;

  for (genvar i = 0; i < NUM_CTX; i++) begin : g_slot
    resv_slot #(
      .ADDR_W     (ADDR_W),
      .GRAN_BITS  (GRAN_BITS),
      .WARN_PERIOD(WARN_PERIOD)
    ) slot_i (
      .clk     (clk),
      .rst_n   (rst_n),
      .sel     (req_ctx == CTX_W'(i)),
      .op      (op),
      .req_addr(req_addr),
      .perform (perform),
      .flag_q  (lock_flags[i]),
      .addr_q  (lock_addrs[i]),
      .sc_pass (pass_vec[i]),
      .sc_fail (fail_vec[i]),
      .warn_hit(warn_vec[i])
    );
  end

  resv_resp resp_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .op        (op),
    .own_flag  (own_flag),
    .perform   (perform),
    .warn_any  (|warn_vec),
    .store_ok  (store_ok),
    .sc_result (sc_result),
    .warn_pulse(warn_pulse)
  );

endmodule

// File: rtl/resv_monitor_chk.sv
module resv_monitor_chk #(
  parameter int NUM_CTX = 4,
  parameter int CTX_W   = 2
) (
  input logic               clk,
  input logic               rst_n,
  input logic               req_valid,
  input logic [CTX_W-1:0]   req_ctx,
  input logic               req_locked,
  input logic               req_store,
  input logic               req_uncached,
  input logic               store_ok,
  input logic               sc_result,
  input logic               warn_pulse,
  input logic [NUM_CTX-1:0] lock_flags,
  input logic               sc_pass_any,
  input logic               sc_fail_any
);

  a_r1_locked_load_arms: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_locked && !req_store && int'(req_ctx) < NUM_CTX)
      |=> lock_flags[$past(req_ctx)]);

  a_r4_failure_disarms: assert property (@(posedge clk) disable iff (!rst_n)
    sc_fail_any |=> (!store_ok && !lock_flags[$past(req_ctx)]));

  a_r5_plain_store_permitted: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_store && !req_locked) |=> store_ok);

  a_r6_success_disarms_own: assert property (@(posedge clk) disable iff (!rst_n)
    sc_pass_any |=> (store_ok && !lock_flags[$past(req_ctx)]));

  a_r7_warn_after_failure: assert property (@(posedge clk) disable iff (!rst_n)
    warn_pulse |-> $past(sc_fail_any));

  a_r9_uncached_bypass: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_store && req_locked && req_uncached)
      |=> (store_ok && $stable(sc_result)));

  a_r11_no_store_no_permit: assert property (@(posedge clk) disable iff (!rst_n)
    (!req_valid || !req_store) |=> !store_ok);

endmodule

bind resv_monitor resv_monitor_chk #(
  .NUM_CTX(NUM_CTX),
  .CTX_W  (CTX_W)
) chk_i (
  .clk         (clk),
  .rst_n       (rst_n),
  .req_valid   (req_valid),
  .req_ctx     (req_ctx),
  .req_locked  (req_locked),
  .req_store   (req_store),
  .req_uncached(req_uncached),
  .store_ok    (store_ok),
  .sc_result   (sc_result),
  .warn_pulse  (warn_pulse),
  .lock_flags  (lock_flags),
  .sc_pass_any (sc_pass_any),
  .sc_fail_any (sc_fail_any)
);

// File: tb/resv_monitor_tb.sv
`timescale 1ns/1ps
module resv_monitor_tb_top;

  localparam int NCTX   = 4;
  localparam int PERIOD = 5;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic [1:0]  req_ctx = '0;
  logic [31:0] req_addr = '0;
  logic        req_locked = 1'b0;
  logic        req_store = 1'b0;
  logic        req_uncached = 1'b0;
  logic        store_ok, sc_result, warn_pulse;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  always #2 clk = ~clk;

  resv_monitor #(
    .NUM_CTX(NCTX), .ADDR_W(32), .GRAN_BITS(4), .WARN_PERIOD(PERIOD)
  ) dut_i (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ctx(req_ctx),
    .req_addr(req_addr), .req_locked(req_locked), .req_store(req_store),
    .req_uncached(req_uncached), .store_ok(store_ok), .sc_result(sc_result),
    .warn_pulse(warn_pulse)
  );

  task automatic chk(input string tag, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0b expected %0b", tag, act, exp);
    end
  endtask

  // Present one request at a falling edge; return one cycle later,
  // when the registered response for it is visible.
  task automatic issue(input int ctx, input logic [31:0] a,
                       input bit lk, input bit st, input bit un);
    req_valid = 1'b1; req_ctx = 2'(ctx); req_addr = a;
    req_locked = lk; req_store = st; req_uncached = un;
    @(negedge clk);
    req_valid = 1'b0; req_locked = 1'b0; req_store = 1'b0; req_uncached = 1'b0;
  endtask

  task automatic ll(input int c, input logic [31:0] a);  issue(c, a, 1, 0, 0); endtask
  task automatic ld(input int c, input logic [31:0] a);  issue(c, a, 0, 0, 0); endtask
  task automatic st(input int c, input logic [31:0] a);  issue(c, a, 0, 1, 0); endtask
  task automatic sc(input int c, input logic [31:0] a);  issue(c, a, 1, 1, 0); endtask
  task automatic scu(input int c, input logic [31:0] a); issue(c, a, 1, 1, 1); endtask

  task automatic t_reset();
    chk("R10 store_ok after reset", store_ok, 0);
    chk("R10 sc_result after reset", sc_result, 0);
    chk("R10 warn after reset", warn_pulse, 0);
    @(negedge clk);
    chk("R11 idle gives no permit", store_ok, 0);
    sc(0, 32'h100);
    chk("R10 no reservation after reset", store_ok, 0);
    chk("R3 result shows disarmed", sc_result, 0);
  endtask

  task automatic t_ll_sc();
    ll(1, 32'h1000);
    chk("R11 locked load no permit", store_ok, 0);
    sc(1, 32'h1000);
    chk("R4 matching sc permitted", store_ok, 1);
    chk("R3 result armed", sc_result, 1);
    sc(1, 32'h1000);
    chk("R6 success disarmed own ctx", store_ok, 0);
    chk("R3 result after disarm", sc_result, 0);
  endtask

  task automatic t_granule();
    ll(0, 32'h2004);
    sc(0, 32'h200C);
    chk("R2 same granule passes", store_ok, 1);
    ll(0, 32'h2004);
    sc(0, 32'h2010);
    chk("R2 next granule refused", store_ok, 0);
    chk("R3 result is armed bit despite mismatch", sc_result, 1);
    sc(0, 32'h2004);
    chk("R4 failure disarmed ctx", store_ok, 0);
    chk("R3 result after failure", sc_result, 0);
  endtask

  task automatic t_clear_all();
    ll(0, 32'h3000);
    ll(1, 32'h3008);
    ll(2, 32'h4000);
    st(3, 32'h300F);
    chk("R5 plain store permitted", store_ok, 1);
    sc(2, 32'h4000);
    chk("R6 other granule kept", store_ok, 1);
    sc(0, 32'h3000);
    chk("R6 ctx0 cleared by store", store_ok, 0);
    sc(1, 32'h3008);
    chk("R6 ctx1 cleared by store", store_ok, 0);
  endtask

  task automatic t_loads();
    ll(0, 32'h5000);
    ld(0, 32'h6000);
    chk("R11 plain load no permit", store_ok, 0);
    ld(1, 32'h5000);
    sc(0, 32'h5000);
    chk("R1 plain loads leave reservation", store_ok, 1);
    ll(0, 32'h5000);
    ll(0, 32'h7000);
    sc(0, 32'h5000);
    chk("R1 newer reservation replaces older", store_ok, 0);
    chk("R1 context still armed", sc_result, 1);
  endtask

  task automatic t_uncached();
    ll(2, 32'h8000);
    sc(2, 32'h8000);
    chk("R4 setup sc", sc_result, 1);
    scu(2, 32'h9000);
    chk("R9 uncached sc permitted", store_ok, 1);
    chk("R9 result kept at 1", sc_result, 1);
    sc(1, 32'h9000);
    chk("R3 failed sc result", sc_result, 0);
    scu(1, 32'h9000);
    chk("R9 result kept at 0", sc_result, 0);
    ll(0, 32'hA000);
    scu(3, 32'hA004);
    chk("R9 permitted", store_ok, 1);
    sc(0, 32'hA000);
    chk("R9 uncached sc cleared ctx0", store_ok, 0);
  endtask

  task automatic t_warn();
    for (int k = 0; k < 4; k++) begin
      sc(3, 32'hB000);
      chk("R7 no warn before period", warn_pulse, 0);
    end
    sc(3, 32'hB000);
    chk("R7 warn on fifth failure", warn_pulse, 1);
    sc(3, 32'hB000);
    chk("R7 warn is one cycle", warn_pulse, 0);
    ll(3, 32'hB000);
    sc(3, 32'hB000);
    chk("R8 success permitted", store_ok, 1);
    for (int k = 0; k < 4; k++) begin
      sc(3, 32'hB000);
      chk("R8 count restarted", warn_pulse, 0);
    end
    sc(3, 32'hB000);
    chk("R8 warn after restarted run", warn_pulse, 1);
    for (int k = 0; k < 4; k++) sc(3, 32'hB000);
    scu(3, 32'hB000);
    for (int k = 0; k < 4; k++) begin
      sc(3, 32'hB000);
      chk("R9 uncached restarted count", warn_pulse, 0);
    end
    sc(2, 32'hB000);
    chk("R7 other ctx no warn", warn_pulse, 0);
    sc(3, 32'hB000);
    chk("R7 per-context count", warn_pulse, 1);
  endtask

  task automatic report();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_ll_sc();
    t_granule();
    t_clear_all();
    t_loads();
    t_uncached();
    t_warn();
    done = 1;
    report();
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      report();
    end
  end

endmodule